// File: doc/BRIEF.md
# UART Receive Buffer with Level Flags

This block holds characters that a serial receiver has already assembled, until host software reads them out of the data register. Each stored word is 12 bits wide. Bits 7:0 carry the character and bits 11:8 carry per-character receive status, with bit 10 meaning a line break. The receiver offers a word on `rx_valid` and watches `rx_can_accept`. A detected break is offered on `rx_break`, and the block stores it as the fixed word 12'h400. A host read of the data register is shown as a one-cycle `rd_pop` strobe. The word at the head is always visible on `rd_data`. The status bits of the most recently popped word are held on `rd_status`.

A mode input selects the depth. With `fifo_en` high the buffer is a 16-entry circular queue, addressed by a read position and a fill count. The write slot is (read position + count) modulo 16. With `fifo_en` low it behaves as a single holding register. The block registers `fifo_en`. In any cycle where the input differs from the registered mode, the buffer is flushed. The block also produces empty and full flags, and a receive interrupt level with one-cycle raise and clear event pulses. The interrupt trigger level is fixed at one entry.

Fill tracking is a three-state machine. The states are FILL_EMPTY (no word held), FILL_PART (some words held, below capacity) and FILL_FULL (count equals capacity). The transitions are:
- fill: FILL_EMPTY to FILL_PART, on an accepted push below capacity.
- fill_one: FILL_EMPTY to FILL_FULL, on an accepted push that reaches capacity, which is always the case in single mode.
- top_up: FILL_PART to FILL_FULL.
- drain: FILL_PART to FILL_EMPTY.
- unload: FILL_FULL to FILL_PART.
- unload_last: FILL_FULL to FILL_EMPTY.
- flush: any state to FILL_EMPTY.

Top module: `uart_rxbuf`

## Requirements
- R1: Accepted words come out on `rd_data` in the order they were pushed, with all 12 bits intact. `rd_data` always shows the entry at the read position. It advances in the cycle after an accepted pop.
- R2: Capacity is 16 when the registered mode is high and 1 when it is low. `rx_can_accept` is high exactly when the count is below the capacity.
- R3: `rx_empty` is high exactly when the count is 0. `rx_full` is high exactly when the count equals the capacity. Both follow in the cycle after the push or pop.
- R4: A push, data or break, offered while `rx_can_accept` is low is dropped. Contents, head word and flags stay unchanged.
- R5: A pop while empty changes no count, no read position and no flag. `rd_data` keeps showing the entry at the current read position.
- R6: In the cycle after any pop that is not in a flush cycle, including a pop while empty, `rd_status` equals bits 11:8 of the word that `rd_data` showed during the pop. At reset it is 0.
- R7: `rx_break` pushes the word 12'h400 (bit 10 set, character 0). When `rx_valid` is high in the same cycle, the break wins and the data word is dropped.
- R8: A cycle in which `fifo_en` differs from the registered mode sets the count and the read position to 0, so `rd_data` shows entry 0. Push and pop are ignored in that cycle. The new capacity applies from the next cycle.
- R9: An accepted push that leaves the count at 1 sets `rx_irq` and pulses `irq_raise` for one cycle. A pop that leaves the count at 0 clears `rx_irq` and pulses `irq_clear` for one cycle. A flush leaves `rx_irq` unchanged.
- R10: A push and a pop in the same cycle, with the count above 0 and below capacity, both take effect and leave the count unchanged.
- R11: After reset the buffer is in single mode and empty, not full, accepting. `rx_irq`, both pulses and `rd_status` are 0. Every entry is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_en | input | 1 | Mode: 1 selects the 16-deep queue, 0 the single register; a change flushes |
| rx_valid | input | 1 | Receiver offers `rx_word` this cycle |
| rx_word | input | 12 | Received character (7:0) with status bits (11:8) |
| rx_break | input | 1 | Receiver detected a break; stores 12'h400 |
| rd_pop | input | 1 | Host read of the data register |
| rd_data | output | 12 | Word at the read position |
| rd_status | output | 4 | Status bits of the last popped word |
| rx_can_accept | output | 1 | Buffer has room for one more word |
| rx_full | output | 1 | Count equals capacity |
| rx_empty | output | 1 | Count is zero |
| rx_irq | output | 1 | Receive interrupt level |
| irq_raise | output | 1 | One-cycle pulse when `rx_irq` is set |
| irq_clear | output | 1 | One-cycle pulse when `rx_irq` is cleared |

## Verification
Flags, `rd_data`, `rd_status`, `rx_irq` and both pulses all settle one clock edge after the push, pop or mode change that causes them. `rx_can_accept` follows directly from the registered count, so it is also due one edge later. The bench drives inputs a quarter period after a rising edge and keeps them for one edge. It updates its reference model for that edge, then samples every output a quarter period after the edge. Each result is therefore compared in the exact cycle it is due. Directed sequences cover filling to 16, overflow, pops while empty, a break colliding with data, simultaneous push and pop, mode flushes and single-register mode. Seeded random traffic then mixes these cases.

// File: rtl/uart_rxbuf_pkg.sv
package uart_rxbuf_pkg;

    typedef enum logic [1:0] {
        FILL_EMPTY = 2'd0,
        FILL_PART  = 2'd1,
        FILL_FULL  = 2'd2
    } fill_state_e;

endpackage

// File: rtl/uart_rxbuf_store.sv
module uart_rxbuf_store #(
    parameter int WORD_W = 12,
    parameter int DEPTH  = 16,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_ptr,
    input  logic [WORD_W-1:0] wr_word,
    input  logic [PTR_W-1:0]  rd_ptr,
    output logic [WORD_W-1:0] rd_word
);

    logic [WORD_W-1:0] slot_q [DEPTH];

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q[gi] <= '0;
            end else if (wr_en && (wr_ptr == PTR_W'(gi))) begin
                slot_q[gi] <= wr_word;
            end
        end
    end

    assign rd_word = slot_q[rd_ptr];

endmodule

// File: rtl/uart_rxbuf_ctrl.sv
module uart_rxbuf_ctrl
    import uart_rxbuf_pkg::*;
#(
    parameter int DEPTH  = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_en,
    input  logic             push_req,
    input  logic             pop_req,
    output logic             mode_q,
    output logic             flush,
    output logic             push_go,
    output logic             pop_take,
    output logic             pop_go,
    output logic [CNT_W-1:0] cnt_nxt,
    output logic [PTR_W-1:0] rd_ptr,
    output logic [PTR_W-1:0] wr_ptr,
    output logic             can_accept,
    output logic             is_empty,
    output logic             is_full
);

    fill_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [PTR_W-1:0] rd_q, rd_d;
    logic [CNT_W-1:0] cap_val;
    logic [CNT_W:0]   slot_sum;

    // capacity follows the registered mode
    assign cap_val    = mode_q ? CNT_W'(DEPTH) : CNT_W'(1);
    assign flush      = (fifo_en != mode_q);
    assign can_accept = (cnt_q < cap_val);
    assign push_go    = !flush && push_req && can_accept;
    assign pop_take   = !flush && pop_req;
    assign pop_go     = pop_take && (cnt_q != '0);

    always_comb begin
        if (flush) begin
            cnt_nxt = '0;
        end else begin
            cnt_nxt = cnt_q + CNT_W'(push_go) - CNT_W'(pop_go);
        end
    end

    // write slot: (read position + count) modulo depth
    always_comb begin
        slot_sum = {1'b0, cnt_q} + (CNT_W + 1)'(rd_q);
        if (slot_sum >= (CNT_W + 1)'(DEPTH)) begin
            slot_sum = slot_sum - (CNT_W + 1)'(DEPTH);
        end
        wr_ptr = PTR_W'(slot_sum);
    end

    always_comb begin
        rd_d = rd_q;
        if (flush) begin
            rd_d = '0;
        end else if (pop_go) begin
            rd_d = (rd_q == PTR_W'(DEPTH - 1)) ? '0 : rd_q + PTR_W'(1);
        end
    end

    // next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FILL_EMPTY: begin
                if (flush) begin
                    state_d = FILL_EMPTY;                  // flush
                end else if (push_go) begin
                    state_d = (cnt_nxt == cap_val) ? FILL_FULL   // fill_one
                                                   : FILL_PART;  // fill
                end
            end
            FILL_PART: begin
                if (flush || cnt_nxt == '0) begin
                    state_d = FILL_EMPTY;                  // flush / drain
                end else if (cnt_nxt == cap_val) begin
                    state_d = FILL_FULL;                   // top_up
                end
            end
            FILL_FULL: begin
                if (flush || cnt_nxt == '0) begin
                    state_d = FILL_EMPTY;                  // flush / unload_last
                end else if (cnt_nxt < cap_val) begin
                    state_d = FILL_PART;                   // unload
                end
            end
            default: state_d = FILL_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FILL_EMPTY;
            cnt_q   <= '0;
            rd_q    <= '0;
            mode_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_nxt;
            rd_q    <= rd_d;
            mode_q  <= fifo_en;
        end
    end

    // outputs
    always_comb begin
        is_empty = (state_q == FILL_EMPTY);
        is_full  = (state_q == FILL_FULL);
        rd_ptr   = rd_q;
    end

endmodule

// File: rtl/uart_rxbuf_irq.sv
module uart_rxbuf_irq #(
    parameter int STAT_W   = 4,
    parameter int CNT_W    = 5,
    parameter int TRIG_LVL = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_go,
    input  logic              pop_go,
    input  logic              pop_take,
    input  logic [CNT_W-1:0]  cnt_nxt,
    input  logic [STAT_W-1:0] head_stat,
    output logic              irq_q,
    output logic              raise_q,
    output logic              clear_q,
    output logic [STAT_W-1:0] stat_q
);

    logic raise_d, clear_d;

    assign raise_d = push_go && (cnt_nxt == CNT_W'(TRIG_LVL));
    assign clear_d = !raise_d && pop_go && (cnt_nxt == CNT_W'(TRIG_LVL - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q   <= 1'b0;
            raise_q <= 1'b0;
            clear_q <= 1'b0;
            stat_q  <= '0;
        end else begin
            raise_q <= raise_d;
            clear_q <= clear_d;
            if (raise_d) begin
                irq_q <= 1'b1;
            end else if (clear_d) begin
                irq_q <= 1'b0;
            end
            if (pop_take) begin
                stat_q <= head_stat;
            end
        end
    end

endmodule

// File: rtl/uart_rxbuf.sv
module uart_rxbuf #(
    parameter int WORD_W    = 12,
    parameter int DEPTH     = 16,
    parameter int TRIG_LVL  = 1,
    parameter int BREAK_BIT = 10,
    localparam int PTR_W    = $clog2(DEPTH),
    localparam int CNT_W    = $clog2(DEPTH + 1),
    localparam int STAT_W   = WORD_W - 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_en,
    input  logic              rx_valid,
    input  logic [WORD_W-1:0] rx_word,
    input  logic              rx_break,
    input  logic              rd_pop,
    output logic [WORD_W-1:0] rd_data,
    output logic [STAT_W-1:0] rd_status,
    output logic              rx_can_accept,
    output logic              rx_full,
    output logic              rx_empty,
    output logic              rx_irq,
    output logic              irq_raise,
    output logic              irq_clear
);

    localparam logic [WORD_W-1:0] BREAK_WORD = WORD_W'(1) << BREAK_BIT;

    logic             mode_q, flush, push_go, pop_take, pop_go;
    logic [CNT_W-1:0] cnt_nxt;
    logic [PTR_W-1:0] rd_ptr, wr_ptr;
    logic [WORD_W-1:0] wr_word;

    // a break outranks a data word in the same cycle
    assign wr_word = rx_break ? BREAK_WORD : rx_word;

    uart_rxbuf_ctrl #(.DEPTH(DEPTH)) ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .fifo_en    (fifo_en),
        .push_req   (rx_valid | rx_break),
        .pop_req    (rd_pop),
        .mode_q     (mode_q),
        .flush      (flush),
        .push_go    (push_go),
        .pop_take   (pop_take),
        .pop_go     (pop_go),
        .cnt_nxt    (cnt_nxt),
        .rd_ptr     (rd_ptr),
        .wr_ptr     (wr_ptr),
        .can_accept (rx_can_accept),
        .is_empty   (rx_empty),
        .is_full    (rx_full)
    );

    uart_rxbuf_store #(.WORD_W(WORD_W), .DEPTH(DEPTH)) store_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (push_go),
        .wr_ptr  (wr_ptr),
        .wr_word (wr_word),
        .rd_ptr  (rd_ptr),
        .rd_word (rd_data)
    );

    uart_rxbuf_irq #(.STAT_W(STAT_W), .CNT_W(CNT_W), .TRIG_LVL(TRIG_LVL)) irq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_go   (push_go),
        .pop_go    (pop_go),
        .pop_take  (pop_take),
        .cnt_nxt   (cnt_nxt),
        .head_stat (rd_data[WORD_W-1:8]),
        .irq_q     (rx_irq),
        .raise_q   (irq_raise),
        .clear_q   (irq_clear),
        .stat_q    (rd_status)
    );

endmodule

// File: rtl/uart_rxbuf_chk.sv
module uart_rxbuf_chk #(
    parameter int WORD_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fifo_en,
    input logic              mode_q,
    input logic              rx_valid,
    input logic              rx_break,
    input logic              rd_pop,
    input logic [WORD_W-1:0] rd_data,
    input logic              rx_can_accept,
    input logic              rx_full,
    input logic              rx_empty,
    input logic              rx_irq,
    input logic              irq_raise,
    input logic              irq_clear
);

    // R3
    flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_full && rx_empty));

    // R2
    accept_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_can_accept == !rx_full);

    // R4
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full && !rd_pop && (fifo_en == mode_q)) |=> (rx_full && $stable(rd_data)));

    // R5
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_empty && rd_pop && !rx_valid && !rx_break && (fifo_en == mode_q))
        |=> (rx_empty && $stable(rd_data)));

    // R8
    flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en != mode_q) |=> (rx_empty && !rx_full));

    // R9
    raise_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_raise |-> rx_irq);

    // R9
    clear_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_clear |-> !rx_irq);

    // R9
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_raise && irq_clear));

endmodule

bind uart_rxbuf uart_rxbuf_chk #(.WORD_W(WORD_W)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .fifo_en       (fifo_en),
    .mode_q        (mode_q),
    .rx_valid      (rx_valid),
    .rx_break      (rx_break),
    .rd_pop        (rd_pop),
    .rd_data       (rd_data),
    .rx_can_accept (rx_can_accept),
    .rx_full       (rx_full),
    .rx_empty      (rx_empty),
    .rx_irq        (rx_irq),
    .irq_raise     (irq_raise),
    .irq_clear     (irq_clear)
);

// File: tb/uart_rxbuf_tb_top.sv
module uart_rxbuf_tb_top;

    localparam int CLK_P = 10;
    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fifo_en = 1'b0;
    logic        rx_valid = 1'b0;
    logic [11:0] rx_word = '0;
    logic        rx_break = 1'b0;
    logic        rd_pop = 1'b0;
    logic [11:0] rd_data;
    logic [3:0]  rd_status;
    logic        rx_can_accept, rx_full, rx_empty, rx_irq, irq_raise, irq_clear;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // reference model state
    logic [11:0] m_mem [DEPTH];
    int          m_rd, m_cnt;
    logic        m_mode, m_irq, m_raise, m_clear;
    logic [3:0]  m_stat;

    always #(CLK_P/2) clk = ~clk;

    uart_rxbuf dut_i (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .rx_valid(rx_valid),
        .rx_word(rx_word), .rx_break(rx_break), .rd_pop(rd_pop),
        .rd_data(rd_data), .rd_status(rd_status), .rx_can_accept(rx_can_accept),
        .rx_full(rx_full), .rx_empty(rx_empty), .rx_irq(rx_irq),
        .irq_raise(irq_raise), .irq_clear(irq_clear)
    );

    function automatic int exp_cap(input logic mode);
        return mode ? DEPTH : 1;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
        m_rd = 0; m_cnt = 0; m_mode = 0; m_irq = 0; m_raise = 0; m_clear = 0; m_stat = '0;
    endtask

    task automatic model_edge(input logic en, input logic v, input logic [11:0] w,
                              input logic brk, input logic pop);
        bit pe, po;
        m_raise = 0; m_clear = 0;
        if (en != m_mode) begin
            m_mode = en; m_cnt = 0; m_rd = 0;
        end else begin
            pe = (v || brk) && (m_cnt < exp_cap(m_mode));
            po = pop && (m_cnt > 0);
            if (pop) m_stat = m_mem[m_rd][11:8];
            if (pe) m_mem[(m_rd + m_cnt) % DEPTH] = brk ? 12'h400 : w;
            if (po) m_rd = (m_rd + 1) % DEPTH;
            m_cnt = m_cnt + int'(pe) - int'(po);
            if (pe && m_cnt == 1) begin
                m_irq = 1; m_raise = 1;
            end else if (po && m_cnt == 0) begin
                m_irq = 0; m_clear = 1;
            end
        end
    endtask

    task automatic check_all();
        chk("R1 rd_data",      32'(rd_data),       32'(m_mem[m_rd]));
        chk("R2 can_accept",   32'(rx_can_accept), 32'(m_cnt < exp_cap(m_mode)));
        chk("R3 rx_empty",     32'(rx_empty),      32'(m_cnt == 0));
        chk("R3 rx_full",      32'(rx_full),       32'(m_cnt == exp_cap(m_mode)));
        chk("R6 rd_status",    32'(rd_status),     32'(m_stat));
        chk("R9 rx_irq",       32'(rx_irq),        32'(m_irq));
        chk("R9 irq_raise",    32'(irq_raise),     32'(m_raise));
        chk("R9 irq_clear",    32'(irq_clear),     32'(m_clear));
    endtask

    // drive one cycle, then sample a quarter period after the edge
    task automatic step(input logic en, input logic v, input logic [11:0] w,
                        input logic brk, input logic pop);
        fifo_en = en; rx_valid = v; rx_word = w; rx_break = brk; rd_pop = pop;
        @(posedge clk);
        model_edge(en, v, w, brk, pop);
        #(CLK_P/4);
        rx_valid = 0; rx_break = 0; rd_pop = 0;
        check_all();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [11:0] held;
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(posedge clk);
        #(CLK_P/4);
        // R11 reset state
        chk("R11 empty",  32'(rx_empty), 1);
        chk("R11 full",   32'(rx_full), 0);
        chk("R11 accept", 32'(rx_can_accept), 1);
        chk("R11 irq",    32'(rx_irq), 0);
        chk("R11 status", 32'(rd_status), 0);
        chk("R11 data",   32'(rd_data), 0);
        rst_n = 1'b1;

        // R5 pop while empty right after reset
        step(0, 0, 0, 0, 1);
        chk("R5 empty after pop", 32'(rx_empty), 1);

        // single mode (R2): one word fills, second is dropped (R4)
        step(0, 1, 12'h241, 0, 0);
        chk("R2 single full", 32'(rx_full), 1);
        step(0, 1, 12'h0AA, 0, 0);
        chk("R4 single drop", 32'(rd_data), 32'h241);
        step(0, 0, 0, 0, 1);
        chk("R6 status single", 32'(rd_status), 32'h2);

        // enable queue: flush cycle, pushes ignored (R8)
        step(1, 1, 12'h123, 0, 0);
        chk("R8 flush empty", 32'(rx_empty), 1);
        for (int i = 0; i < DEPTH; i++) step(1, 1, 12'(12'h100 + i), 0, 0);
        chk("R2 queue full", 32'(rx_can_accept), 0);
        step(1, 1, 12'hFFF, 0, 0);
        chk("R4 overflow drop head", 32'(rd_data), 32'h100);
        step(1, 0, 0, 1, 0);
        chk("R4 break drop full", 32'(rx_full), 1);
        for (int i = 0; i < DEPTH; i++) begin
            chk("R1 order", 32'(rd_data), 32'(12'h100 + i));
            step(1, 0, 0, 0, 1);
        end
        chk("R3 drained", 32'(rx_empty), 1);

        // R5 pop at wrapped read position
        held = rd_data;
        step(1, 0, 0, 0, 1);
        chk("R5 data kept", 32'(rd_data), 32'(held));

        // R7 break beats data
        step(1, 1, 12'h0C3, 1, 0);
        chk("R7 break word", 32'(rd_data), 32'h400);
        step(1, 0, 0, 0, 1);
        chk("R7 break only", 32'(rx_empty), 1);
        chk("R6 break status", 32'(rd_status), 32'h4);

        // R10 simultaneous push and pop
        step(1, 1, 12'h311, 0, 0);
        step(1, 1, 12'h322, 0, 0);
        step(1, 1, 12'h333, 0, 1);
        chk("R10 head", 32'(rd_data), 32'h322);
        chk("R10 not empty", 32'(rx_empty), 0);

        // R8 flush with data held, read position back to 0
        step(0, 0, 0, 0, 0);
        chk("R8 flush empty2", 32'(rx_empty), 1);
        chk("R8 slot0", 32'(rd_data), 32'(m_mem[0]));
        chk("R9 irq kept on flush", 32'(rx_irq), 1);

        // seeded random traffic
        for (int n = 0; n < 6000; n++) begin
            logic en_r;
            en_r = fifo_en;
            if (($urandom % 96) == 0) en_r = ~fifo_en;
            step(en_r, ($urandom % 2) == 0, 12'($urandom), ($urandom % 32) == 0,
                 ($urandom % 5) < 2);
        end
        finish_run();
    end

endmodule